// File: doc/BRIEF.md
# Parallel-Column LED Panel Loader

This block refreshes a bank of 71 front-panel indicator LEDs that sit behind nine external serial-in, parallel-out shift registers. Eight of these registers share one shift clock, and each one takes a single bit of a byte on every write. The ninth register has its own data line and its own shift clock. All nine share one latch-enable line, which copies the shift contents to the LED drivers.

A host places a 71-bit LED image on the input and pulses an update request. The block captures the image and transposes it into eight column bytes for the shared group, so that group register `i` receives LEDs `8*i` to `8*i+7` over eight writes. It then sends eight serial bits to the ninth register, which carries LEDs 64 to 70 and one zero padding bit. Last, it pulses the latch once. A request that arrives while a refresh is running is held as one pending request. The pending refresh then uses the image present at the moment it starts.

Top module: `pled_loader`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `grp_sclk_o`, `aux_sclk_o`, `latch_o`, `aux_data_o` and every bit of `grp_data_o` are 0.
- R2: A request sampled high at a clock edge while idle raises `busy_o` in the next cycle. `busy_o` then stays high for exactly 65 cycles: 16 writes of 4 cycles each, plus one latch cycle. It is low in the cycle after the latch pulse unless another refresh starts.
- R3: Writes 0 to 7 go to the shared group. On group write `k`, `grp_data_o[i]` carries image bit `8*i+k`. An external register that shifts toward its MSB therefore ends with LED `8*i+k` in its bit `7-k`.
- R4: Writes 8 to 15 go to the separate register. On write `8+j`, `aux_data_o` carries image bit `64+j` for `j` from 0 to 6, and 0 for `j` = 7. `grp_sclk_o` and `aux_sclk_o` are never high in the same cycle.
- R5: Each write lasts 4 cycles. Data is valid with its clock low for one cycle, the clock is then high for exactly two cycles, and the clock is low again for one cycle with the data unchanged.
- R6: After the hold cycle of write 15, `latch_o` is high for exactly one cycle, with both shift clocks low. There is one latch pulse per refresh.
- R7: Requests that arrive while busy, including those in the latch cycle, are merged into a single pending refresh. It starts in the cycle right after the latch pulse, so `busy_o` stays high with no gap.
- R8: A refresh shows the image present on `led_img_i` at the clock edge where that refresh starts. Images presented between a queued request and that edge do not appear.
- R9: `grp_data_o` is 0 outside group writes and `aux_data_o` is 0 outside writes to the separate register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_req_i | input | 1 | Update request, sampled each clock edge |
| led_img_i | input | 71 | LED image; bit n drives LED n |
| busy_o | output | 1 | A refresh is in progress |
| grp_data_o | output | 8 | One data bit per shared-group register |
| grp_sclk_o | output | 1 | Shift clock of the shared group |
| aux_data_o | output | 1 | Data bit of the separate register |
| aux_sclk_o | output | 1 | Shift clock of the separate register |
| latch_o | output | 1 | Latch-enable pulse for all nine registers |

## Verification
The collision of interest is between the latch cycle that ends one refresh and the start of a new one. A request can be taken in the same cycle the latch pulse goes out, and the sequencer must then restart without losing a cycle or dropping the pulse. The bench provokes this in two ways: by raising the request exactly in the latch cycle, and by queueing several requests early and changing the image afterwards. It models the nine external registers from the output pins and judges the case by three things: two single-cycle latch pulses, an unbroken busy window of 130 cycles, and a second latched image that equals the newest input.

// File: rtl/pled_pkg.sv
package pled_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_LATCH = 2'd2
  } sq_state_e;

endpackage

// File: rtl/pled_req_ctrl.sv
module pled_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic idle_i,
  input  logic last_i,
  output logic start_o,
  output logic pend_o
);

  logic pend_q;
  logic pend_d;

  // A refresh may begin from idle or straight out of the latch cycle.
  always_comb begin
    start_o = (idle_i || last_i) && (req_i || pend_q);
    if (start_o) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q || (req_i && !idle_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R7
  pend_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !idle_i);

  // R7
  pend_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && last_i) |=> !idle_i);

endmodule

// File: rtl/pled_image_reg.sv
module pled_image_reg #(
  parameter int unsigned N_LED = 71
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en_i,
  input  logic [N_LED-1:0] img_i,
  output logic [N_LED-1:0] img_o
);

  logic [N_LED-1:0] img_q;
  logic [N_LED-1:0] img_d;

  always_comb begin
    img_d = img_q;
    if (cap_en_i) begin
      img_d = img_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q <= '0;
    end else begin
      img_q <= img_d;
    end
  end

  assign img_o = img_q;

  // R8
  img_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en_i |=> (img_o == $past(img_i)));

endmodule

// File: rtl/pled_sequencer.sv
module pled_sequencer
  import pled_pkg::*;
#(
  parameter int unsigned REG_BITS  = 8,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned HIGH_CYC  = 2,
  parameter int unsigned HOLD_CYC  = 1,
  localparam int unsigned KW       = $clog2(REG_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          idle_o,
  output logic          last_o,
  output logic          grp_phase_o,
  output logic          aux_phase_o,
  output logic [KW-1:0] sel_o,
  output logic          grp_sclk_o,
  output logic          aux_sclk_o,
  output logic          latch_o
);

  localparam int unsigned WR_W   = KW + 1;
  localparam int unsigned TOT_WR = 2 * REG_BITS;
  localparam int unsigned PH_CYC = SETUP_CYC + HIGH_CYC + HOLD_CYC;
  localparam int unsigned PH_W   = (PH_CYC > 1) ? $clog2(PH_CYC) : 1;
  localparam int unsigned HL_W   = $clog2(HIGH_CYC + 2);

  sq_state_e        state_q, state_d;
  logic [WR_W-1:0]  wr_q, wr_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             gsclk_q, gsclk_d;
  logic             asclk_q, asclk_d;
  logic             latch_q, latch_d;
  logic             last_wr;
  logic             last_ph;
  logic             hi_win;

  assign last_wr = (wr_q == WR_W'(TOT_WR - 1));
  assign last_ph = (ph_q == PH_W'(PH_CYC - 1));

  // Next state: write index and phase within the write.
  always_comb begin
    state_d = state_q;
    wr_d    = wr_q;
    ph_d    = ph_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          state_d = SQ_SHIFT;
          wr_d    = '0;
          ph_d    = '0;
        end
      end
      SQ_SHIFT: begin
        if (last_ph) begin
          ph_d = '0;
          if (last_wr) begin
            state_d = SQ_LATCH;
            wr_d    = '0;
          end else begin
            wr_d = wr_q + WR_W'(1);
          end
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      SQ_LATCH: begin
        wr_d = '0;
        ph_d = '0;
        if (start_i) begin
          state_d = SQ_SHIFT;
        end else begin
          state_d = SQ_IDLE;
        end
      end
      default: begin
        state_d = SQ_IDLE;
        wr_d    = '0;
        ph_d    = '0;
      end
    endcase
  end

  // Strobes are decoded from the next state and registered (glitch-free pins).
  always_comb begin
    hi_win  = (ph_d >= PH_W'(SETUP_CYC)) && (ph_d < PH_W'(SETUP_CYC + HIGH_CYC));
    gsclk_d = (state_d == SQ_SHIFT) && !wr_d[KW] && hi_win;
    asclk_d = (state_d == SQ_SHIFT) &&  wr_d[KW] && hi_win;
    latch_d = (state_d == SQ_LATCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      wr_q    <= '0;
      ph_q    <= '0;
      gsclk_q <= 1'b0;
      asclk_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      ph_q    <= ph_d;
      gsclk_q <= gsclk_d;
      asclk_q <= asclk_d;
      latch_q <= latch_d;
    end
  end

  assign idle_o      = (state_q == SQ_IDLE);
  assign last_o      = (state_q == SQ_LATCH);
  assign grp_phase_o = (state_q == SQ_SHIFT) && !wr_q[KW];
  assign aux_phase_o = (state_q == SQ_SHIFT) &&  wr_q[KW];
  assign sel_o       = wr_q[KW-1:0];
  assign grp_sclk_o  = gsclk_q;
  assign aux_sclk_o  = asclk_q;
  assign latch_o     = latch_q;

  // Checker-side run length of the shift clock high time.
  logic            sclk_any;
  logic [HL_W-1:0] hi_len_q;
  assign sclk_any = gsclk_q || asclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len_q <= '0;
    end else if (sclk_any) begin
      hi_len_q <= hi_len_q + HL_W'(1);
    end else begin
      hi_len_q <= '0;
    end
  end

  // R5
  sclk_max_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_any |-> (hi_len_q < HL_W'(HIGH_CYC)));

  // R5
  sclk_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_any) |-> (hi_len_q == HL_W'(HIGH_CYC)));

  // R4
  sclk_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gsclk_q && asclk_q));

  // R6
  latch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |=> !latch_q || !$past(last_o));

  // R6
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |-> (!gsclk_q && !asclk_q && !idle_o));

endmodule

// File: rtl/pled_col_mux.sv
module pled_col_mux #(
  parameter int unsigned GRP_REGS = 8,
  parameter int unsigned REG_BITS = 8,
  parameter int unsigned N_LED    = 71,
  localparam int unsigned KW      = $clog2(REG_BITS)
) (
  input  logic [N_LED-1:0]    img_i,
  input  logic [KW-1:0]       sel_i,
  input  logic                grp_en_i,
  input  logic                aux_en_i,
  output logic [GRP_REGS-1:0] grp_data_o,
  output logic                aux_data_o
);

  localparam int unsigned N_GRP = GRP_REGS * REG_BITS;

  // Each group register owns one row of REG_BITS image bits; the write
  // index picks the column, which transposes the image into bytes.
  for (genvar gi = 0; gi < GRP_REGS; gi++) begin : g_row
    logic [REG_BITS-1:0] row;
    assign row            = img_i[gi*REG_BITS +: REG_BITS];
    assign grp_data_o[gi] = grp_en_i & row[sel_i];
  end

  logic [REG_BITS-1:0] aux_row;
  for (genvar aj = 0; aj < REG_BITS; aj++) begin : g_aux
    if (N_GRP + aj < N_LED) begin : g_led
      assign aux_row[aj] = img_i[N_GRP + aj];
    end else begin : g_pad
      assign aux_row[aj] = 1'b0;
    end
  end

  assign aux_data_o = aux_en_i & aux_row[sel_i];

endmodule

// File: rtl/pled_loader.sv
module pled_loader #(
  parameter int unsigned GRP_REGS  = 8,
  parameter int unsigned REG_BITS  = 8,
  parameter int unsigned N_LED     = 71,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned HIGH_CYC  = 2,
  parameter int unsigned HOLD_CYC  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_req_i,
  input  logic [N_LED-1:0]    led_img_i,
  output logic                busy_o,
  output logic [GRP_REGS-1:0] grp_data_o,
  output logic                grp_sclk_o,
  output logic                aux_data_o,
  output logic                aux_sclk_o,
  output logic                latch_o
);

  localparam int unsigned KW = $clog2(REG_BITS);

  logic             start;
  logic             pend;
  logic             idle;
  logic             last;
  logic             grp_phase;
  logic             aux_phase;
  logic [KW-1:0]    sel;
  logic [N_LED-1:0] img;

  pled_req_ctrl i_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (upd_req_i),
    .idle_i  (idle),
    .last_i  (last),
    .start_o (start),
    .pend_o  (pend)
  );

  pled_image_reg #(.N_LED(N_LED)) i_img (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en_i (start),
    .img_i    (led_img_i),
    .img_o    (img)
  );

  pled_sequencer #(
    .REG_BITS  (REG_BITS),
    .SETUP_CYC (SETUP_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .idle_o      (idle),
    .last_o      (last),
    .grp_phase_o (grp_phase),
    .aux_phase_o (aux_phase),
    .sel_o       (sel),
    .grp_sclk_o  (grp_sclk_o),
    .aux_sclk_o  (aux_sclk_o),
    .latch_o     (latch_o)
  );

  pled_col_mux #(
    .GRP_REGS (GRP_REGS),
    .REG_BITS (REG_BITS),
    .N_LED    (N_LED)
  ) i_mux (
    .img_i      (img),
    .sel_i      (sel),
    .grp_en_i   (grp_phase),
    .aux_en_i   (aux_phase),
    .grp_data_o (grp_data_o),
    .aux_data_o (aux_data_o)
  );

  assign busy_o = !idle;

  // R5
  grp_data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_sclk_o |-> $stable(grp_data_o));

  // R5
  grp_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grp_sclk_o) |-> $stable(grp_data_o));

  // R5
  aux_data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_sclk_o |-> $stable(aux_data_o));

  // R2
  busy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> busy_o);

  // R7
  pend_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && latch_o) |=> busy_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (grp_data_o == '0 && !aux_data_o));

endmodule

// File: tb/test_pled_loader.sv
module test_pled_loader;

  localparam int CLK_PERIOD = 10;
  localparam int N_LED      = 71;
  localparam int SEQ_CYC    = 16 * 4 + 1;
  localparam int WD_CYC     = 20000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             upd_req_i;
  logic [N_LED-1:0] led_img_i;
  logic             busy_o;
  logic [7:0]       grp_data_o;
  logic             grp_sclk_o;
  logic             aux_data_o;
  logic             aux_sclk_o;
  logic             latch_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pled_loader i_pled_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_req_i  (upd_req_i),
    .led_img_i  (led_img_i),
    .busy_o     (busy_o),
    .grp_data_o (grp_data_o),
    .grp_sclk_o (grp_sclk_o),
    .aux_data_o (aux_data_o),
    .aux_sclk_o (aux_sclk_o),
    .latch_o    (latch_o)
  );

  // Model of the nine external registers plus timing bookkeeping.
  logic [7:0]       sr_g [8];
  logic [7:0]       sr_a;
  logic [N_LED-1:0] hist [4];
  logic             pad_hist [4];
  int n_latch, n_grise, n_arise, busy_cnt;
  int width_bad, setup_bad, quiet_bad, g_hi, a_hi;
  logic p_gs, p_as, p_lat, p_ad;
  logic [7:0] p_gd;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) busy_cnt++;
      if (!busy_o && (grp_data_o != 0 || aux_data_o || grp_sclk_o || aux_sclk_o || latch_o))
        quiet_bad++;
      if (grp_sclk_o && aux_data_o) quiet_bad++;
      if (aux_sclk_o && grp_data_o != 0) quiet_bad++;
      if (grp_sclk_o && !p_gs) begin
        n_grise++; g_hi = 1;
        if (grp_data_o != p_gd) setup_bad++;
        for (int i = 0; i < 8; i++) sr_g[i] = {sr_g[i][6:0], grp_data_o[i]};
      end else if (grp_sclk_o) g_hi++;
      if (!grp_sclk_o && p_gs) begin
        if (g_hi != 2) width_bad++;
        if (grp_data_o != p_gd) setup_bad++;
      end
      if (aux_sclk_o && !p_as) begin
        n_arise++; a_hi = 1;
        if (aux_data_o != p_ad) setup_bad++;
        sr_a = {sr_a[6:0], aux_data_o};
      end else if (aux_sclk_o) a_hi++;
      if (!aux_sclk_o && p_as) begin
        if (a_hi != 2) width_bad++;
        if (aux_data_o != p_ad) setup_bad++;
      end
      if (latch_o) begin
        if (p_lat || grp_sclk_o || aux_sclk_o) width_bad++;
        else if (n_latch < 4) begin
          for (int i = 0; i < 8; i++)
            for (int k = 0; k < 8; k++) hist[n_latch][8*i+k] = sr_g[i][7-k];
          for (int j = 0; j < 7; j++) hist[n_latch][64+j] = sr_a[7-j];
          pad_hist[n_latch] = sr_a[0];
          n_latch++;
        end else n_latch++;
      end
      p_gs = grp_sclk_o; p_as = aux_sclk_o; p_lat = latch_o;
      p_gd = grp_data_o; p_ad = aux_data_o;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_img(input string req, input logic [N_LED-1:0] act,
                           input logic [N_LED-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s image: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1;
    n_latch = 0; n_grise = 0; n_arise = 0; busy_cnt = 0;
    width_bad = 0; setup_bad = 0; quiet_bad = 0; g_hi = 0; a_hi = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (busy_o && guard < 1000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    check(busy_o == 0 && latch_o == 0, "R1", "busy/latch in reset", {busy_o, latch_o}, 0);
    check(grp_sclk_o == 0 && aux_sclk_o == 0, "R1", "sclk in reset", {grp_sclk_o, aux_sclk_o}, 0);
    check(grp_data_o == 0 && aux_data_o == 0, "R1", "data in reset", {grp_data_o, aux_data_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_o == 0 && grp_sclk_o == 0 && latch_o == 0, "R1", "after release",
          {busy_o, grp_sclk_o, latch_o}, 0);
  endtask

  // R2 R3 R4 R5 R6 R9
  task automatic t_single(input logic [N_LED-1:0] img, input string tag);
    logic seen_next;
    clear_mon();
    @(negedge clk);
    upd_req_i = 1'b1; led_img_i = img;
    @(negedge clk);
    upd_req_i = 1'b0;
    seen_next = busy_o;
    check(seen_next == 1, "R2", {tag, " busy one cycle after request"}, seen_next, 1);
    wait_idle();
    check(busy_cnt == SEQ_CYC, "R2", {tag, " busy length"}, busy_cnt, SEQ_CYC);
    check(n_latch == 1, "R6", {tag, " latch count"}, n_latch, 1);
    check(n_grise == 8 && n_arise == 8, "R5", {tag, " write counts"}, {n_grise, n_arise}, {8, 8});
    check(width_bad == 0, "R5", {tag, " clock/latch width"}, width_bad, 0);
    check(setup_bad == 0, "R5", {tag, " data setup/hold"}, setup_bad, 0);
    check(quiet_bad == 0, "R9", {tag, " idle data quiet"}, quiet_bad, 0);
    check_img({"R3 R4 ", tag}, hist[0], img);
    check(pad_hist[0] == 0, "R4", {tag, " padding bit"}, pad_hist[0], 0);
  endtask

  // R7 R8: several requests queued early, image changes before the restart
  task automatic t_queue(input logic [N_LED-1:0] a, input logic [N_LED-1:0] b);
    clear_mon();
    @(negedge clk);
    upd_req_i = 1'b1; led_img_i = a;
    @(negedge clk);
    upd_req_i = 1'b0;
    repeat (10) @(negedge clk);
    upd_req_i = 1'b1; led_img_i = ~a;
    repeat (3) @(negedge clk);
    upd_req_i = 1'b0; led_img_i = b;
    wait_idle();
    check(n_latch == 2, "R7", "merged requests give one extra refresh", n_latch, 2);
    check(busy_cnt == 2 * SEQ_CYC, "R7", "no gap between refreshes", busy_cnt, 2 * SEQ_CYC);
    check_img("R8 first", hist[0], a);
    check_img("R8 newest", hist[1], b);
    check(width_bad == 0 && setup_bad == 0, "R5", "queued timing", {width_bad, setup_bad}, 0);
  endtask

  // R6 R7 R8: request raised exactly in the latch cycle
  task automatic t_latch_collide(input logic [N_LED-1:0] a, input logic [N_LED-1:0] b);
    int guard = 0;
    clear_mon();
    @(negedge clk);
    upd_req_i = 1'b1; led_img_i = a;
    @(negedge clk);
    upd_req_i = 1'b0;
    while (!latch_o && guard < 200) begin
      @(negedge clk); guard++;
    end
    upd_req_i = 1'b1; led_img_i = b;
    @(negedge clk);
    upd_req_i = 1'b0;
    check(busy_o == 1 && latch_o == 0, "R7", "restart right after latch", {busy_o, latch_o}, 2'b10);
    wait_idle();
    check(n_latch == 2, "R6", "two single latch pulses", n_latch, 2);
    check(busy_cnt == 2 * SEQ_CYC, "R7", "collide busy length", busy_cnt, 2 * SEQ_CYC);
    check_img("R8 collide first", hist[0], a);
    check_img("R8 collide second", hist[1], b);
    check(width_bad == 0, "R6", "latch width in collision", width_bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; upd_req_i = 1'b0; led_img_i = '0;
    p_gs = 0; p_as = 0; p_lat = 0; p_ad = 0; p_gd = 0; sr_a = 0;
    for (int i = 0; i < 8; i++) sr_g[i] = 0;
    n_latch = 0; busy_cnt = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_single({N_LED{1'b1}}, "all ones");
    t_single(N_LED'({36{2'b01}}), "alternate");
    t_single(N_LED'(1) << 63, "bit 63");
    t_single(N_LED'(1) << 70, "bit 70");
    t_single(N_LED'(71'h4D_3C2B_1A09_F8E7_D6C5), "mixed");
    t_queue(N_LED'(71'h12_3456_789A_BCDE_F012), N_LED'(71'h6E_DCBA_9876_5432_10FE));
    t_latch_collide(N_LED'(71'h0F_0F0F_0F0F_0F0F_0F0F), N_LED'(71'h70_F0F0_F0F0_F0F0_F0F1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule